// File: doc/BRIEF.md
# Three-Wire Serial Register Target

This block is the configuration port of a display driver chip. A host reaches it over a serial bus with three signals: a clock, an active-low select and one data line that both sides share. Each frame starts with a command made of a register address and a direction flag. In a write frame the host then sends one data byte. In a read frame the host lets go of the line, one clock passes with nobody driving it, and the target returns one byte.

The block holds four registers. One is a scratch location that the host uses to test the link. One is a fixed identity byte. One holds a resolution code. One holds an ownership flag and a power flag. The block drives a resolution code output and a standby output. The ownership flag picks where those outputs come from. When it is clear, they follow the strap pins. When it is set, they follow the register contents.

The serial inputs are sampled by the block's own system clock through synchronizers. Serial clock edges are found by comparing successive synchronized samples. The data line appears as three pins, `sdio_i`, `sdio_o` and `sdio_oe`, and the pad combines them outside the block. The serial interface is the only data path. It has no back-pressure: every frame is accepted as it arrives.

Top module: `p3w_reg_target`

## Requirements
- R1: After the active-low reset is released, `sdio_oe` is 0. The ownership flag is 0, so `res_code` equals `strap_res` and `standby` equals the inverse of `strap_active`. The scratch register reads 0x00.
- R2: A frame is decoded on rising serial clock edges, MSB first. Clock edges 1 to 6 carry the address, edge 7 carries the direction (0 = write) and edge 8 is padding whose value has no effect. Edges 9 to 16 carry the data byte, which is committed after the 16th edge. The address bits are ordered so that address 0x20 and address 0x00 are different registers.
- R3: Address 0x00 is a scratch register that can be written and read. Writing 0x55 reads back 0x55, and any other byte reads back unchanged.
- R4: Address 0x01 reads as `{CHIP_ID, CHIP_REV}`, with the identity nibble in bits [7:4] and the revision nibble in bits [3:0]. Writes to this address have no effect.
- R5: In a read frame (direction bit 1), `sdio_oe` is 0 during the 8th clock. The target drives the 8 bits of the byte MSB first. Each bit changes only after a falling serial clock edge, and the host samples it on the next rising edge.
- R6: `sdio_oe` is 1 only for the 8 data clocks of a read frame. It returns to 0 after the falling edge that follows the 16th rising edge.
- R7: Raising `cs_n` in the middle of a frame aborts it. A partly sent write changes no register, and `sdio_oe` returns to 0.
- R8: Address 0x02 holds the resolution code in bits [2:0]. Bits [7:3] read as 0.
- R9: Address 0x03 holds the ownership flag in bit 7 and the power flag in bit 0 (1 = active). Bits [6:1] read as 0.
- R10: While the ownership flag is 0, `res_code`, the read of 0x02 bits [2:0], `standby` and the read of 0x03 bit 0 all follow the straps. Writes to the resolution field are stored but do not reach those outputs.
- R11: While the ownership flag is 1, `res_code` equals the stored resolution field and `standby` is the inverse of the stored power flag. Changes on the strap pins have no effect.
- R12: Addresses 0x04 to 0x3F read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Level seen on the shared data line |
| sdio_o | output | 1 | Bit the target drives during read data |
| sdio_oe | output | 1 | Pad output enable for the shared data line |
| strap_res | input | 3 | Resolution code from the strap pins |
| strap_active | input | 1 | Power state from the strap pins (1 = active) |
| res_code | output | 3 | Resolution code in effect |
| standby | output | 1 | 1 when the panel is in standby |

## Verification
The hardest behaviour to reach is the handover of the shared line. The bench has to show that nobody drives the line during the turnaround clock, that the target drives it for exactly eight clocks, and that it lets go when a frame is cut short. The bench models the line as a resolved bus with a pull-up. It checks `sdio_oe` just before the turnaround rising edge and before every data rising edge. It also flags any cycle in which the host and the target drive the line together. Aborted frames raise `cs_n` partway through a write and partway through a read. After each one, a per-clock comparison against the reference model shows that the line is released and that no register changed.

// File: rtl/p3w_pkg.sv
package p3w_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int CMD_BITS   = ADDR_W + 2;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int RES_W      = 3;
  localparam int ID_W       = DATA_W / 2;
  localparam int OWN_BIT    = DATA_W - 1;
  localparam int ACT_BIT    = 0;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam addr_t A_SCRATCH = addr_t'(0);
  localparam addr_t A_IDENT   = addr_t'(1);
  localparam addr_t A_RES     = addr_t'(2);
  localparam addr_t A_PWR     = addr_t'(3);
endpackage

// File: rtl/p3w_sync.sv
module p3w_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/p3w_front.sv
module p3w_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [2:0] raw_pins;
  logic [2:0] syn_pins;
  logic       sck_prev;

  assign raw_pins = {sclk, cs_n, sdi};

  p3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_pins),
    .q    (syn_pins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= syn_pins[2];
  end

  assign sck_rise = syn_pins[2] & ~sck_prev;
  assign sck_fall = ~syn_pins[2] & sck_prev;
  assign cs_act   = ~syn_pins[1];
  assign sdi_s    = syn_pins[0];
endmodule

// File: rtl/p3w_frame.sv
module p3w_frame
  import p3w_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_act,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  sdi,
  input  byte_t rd_data,
  output addr_t addr,
  output logic  wr_en,
  output byte_t wr_data,
  output logic  sdo,
  output logic  sdo_oe,
  output logic  rd_mode,
  output cnt_t  bit_cnt
);
  byte_t shin;
  byte_t txq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shin    <= '0;
      addr    <= '0;
      rd_mode <= 1'b0;
      txq     <= '0;
      sdo_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        rd_mode <= 1'b0;
        sdo_oe  <= 1'b0;
      end else begin
        if (sck_rise && bit_cnt != cnt_t'(FRAME_BITS)) begin
          bit_cnt <= bit_cnt + cnt_t'(1);
          shin    <= {shin[DATA_W-2:0], sdi};
          if (bit_cnt == cnt_t'(ADDR_W)) begin
            addr    <= shin[ADDR_W-1:0];
            rd_mode <= sdi;
          end
          if (bit_cnt == cnt_t'(FRAME_BITS - 1) && !rd_mode) begin
            wr_en   <= 1'b1;
            wr_data <= {shin[DATA_W-2:0], sdi};
          end
        end
        if (sck_fall && rd_mode) begin
          if (bit_cnt == cnt_t'(CMD_BITS)) begin
            txq    <= rd_data;
            sdo_oe <= 1'b1;
          end else if (bit_cnt == cnt_t'(FRAME_BITS)) begin
            sdo_oe <= 1'b0;
          end else if (bit_cnt > cnt_t'(CMD_BITS)) begin
            txq <= {txq[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sdo = txq[DATA_W-1];
endmodule

// File: rtl/p3w_regs.sv
module p3w_regs
  import p3w_pkg::*;
#(
  parameter logic [ID_W-1:0] CHIP_ID  = 4'h1,
  parameter logic [ID_W-1:0] CHIP_REV = 4'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  addr_t            addr,
  input  byte_t            wr_data,
  input  logic [RES_W-1:0] strap_res,
  input  logic             strap_active,
  output byte_t            rd_data,
  output logic [RES_W-1:0] res_code,
  output logic             standby
);
  localparam byte_t IDENT_BYTE = {CHIP_ID, CHIP_REV};

  byte_t            scratch_q;
  logic [RES_W-1:0] res_q;
  logic             own_q;
  logic             act_q;
  logic [RES_W-1:0] res_eff;
  logic             act_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      res_q     <= '0;
      own_q     <= 1'b0;
      act_q     <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        A_SCRATCH: scratch_q <= wr_data;
        A_RES:     res_q     <= wr_data[RES_W-1:0];
        A_PWR: begin
          own_q <= wr_data[OWN_BIT];
          act_q <= wr_data[ACT_BIT];
        end
        default: ;
      endcase
    end
  end

  assign res_eff = own_q ? res_q : strap_res;
  assign act_eff = own_q ? act_q : strap_active;

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_SCRATCH: rd_data = scratch_q;
      A_IDENT:   rd_data = IDENT_BYTE;
      A_RES:     rd_data[RES_W-1:0] = res_eff;
      A_PWR: begin
        rd_data[OWN_BIT] = own_q;
        rd_data[ACT_BIT] = act_eff;
      end
      default: rd_data = '0;
    endcase
  end

  assign res_code = res_eff;
  assign standby  = ~act_eff;
endmodule

// File: rtl/p3w_reg_target.sv
module p3w_reg_target
  import p3w_pkg::*;
#(
  parameter logic [ID_W-1:0] CHIP_ID     = 4'h1,
  parameter logic [ID_W-1:0] CHIP_REV    = 4'h0,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe,
  input  logic [RES_W-1:0] strap_res,
  input  logic             strap_active,
  output logic [RES_W-1:0] res_code,
  output logic             standby
);
  logic  sck_rise;
  logic  sck_fall;
  logic  cs_act;
  logic  sdi_s;
  addr_t reg_addr;
  logic  wr_en;
  byte_t wr_data;
  byte_t rd_data;
  logic  rd_mode;
  cnt_t  bit_cnt;

  p3w_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .sdi     (sdio_i),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .cs_act  (cs_act),
    .sdi_s   (sdi_s)
  );

  p3w_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_act  (cs_act),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall),
    .sdi     (sdi_s),
    .rd_data (rd_data),
    .addr    (reg_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sdo     (sdio_o),
    .sdo_oe  (sdio_oe),
    .rd_mode (rd_mode),
    .bit_cnt (bit_cnt)
  );

  p3w_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (reg_addr),
    .wr_data     (wr_data),
    .strap_res   (strap_res),
    .strap_active(strap_active),
    .rd_data     (rd_data),
    .res_code    (res_code),
    .standby     (standby)
  );
endmodule

// File: rtl/p3w_reg_target_chk.sv
module p3w_reg_target_chk
  import p3w_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sdio_o,
  input logic             sdio_oe,
  input logic             sck_fall,
  input logic             wr_en,
  input logic             rd_mode,
  input cnt_t             bit_cnt,
  input logic [RES_W-1:0] strap_res,
  input logic             strap_active,
  input logic [RES_W-1:0] res_code,
  input logic             standby
);
  logic [2:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age <= '0;
    else if (age != 3'd7)   age <= age + 3'd1;
  end

  // R7
  cs_idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdio_oe);

  // R5
  oe_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && $rose(sdio_oe)) |-> (rd_mode && bit_cnt == cnt_t'(CMD_BITS)));

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && sdio_oe && $past(sdio_oe) && !$past(sck_fall)) |-> $stable(sdio_o));

  // R2
  wr_in_write_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_mode);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= cnt_t'(FRAME_BITS));

  // R11
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !$past(wr_en) && $stable(strap_active)) |-> $stable(standby));

  // R10
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !$past(wr_en) && $stable(strap_res)) |-> $stable(res_code));
endmodule

bind p3w_reg_target p3w_reg_target_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sdio_o      (sdio_o),
  .sdio_oe     (sdio_oe),
  .sck_fall    (sck_fall),
  .wr_en       (wr_en),
  .rd_mode     (rd_mode),
  .bit_cnt     (bit_cnt),
  .strap_res   (strap_res),
  .strap_active(strap_active),
  .res_code    (res_code),
  .standby     (standby)
);

// File: tb/p3w_reg_target_bench.sv
`timescale 1ns/1ps
module p3w_reg_target_bench;
  localparam int HALF = 8;
  localparam logic [3:0] T_ID  = 4'hA;
  localparam logic [3:0] T_REV = 4'h5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       host_oe = 1'b0;
  logic       host_bit = 1'b0;
  logic       sdio_i;
  logic       sdio_o;
  logic       sdio_oe;
  logic [2:0] strap_res = 3'b101;
  logic       strap_active = 1'b1;
  logic [2:0] res_code;
  logic       standby;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  logic [7:0] m_scratch = 8'h00;
  logic [2:0] m_res = 3'b000;
  logic       m_own = 1'b0;
  logic       m_act = 1'b0;

  always #5 clk = ~clk;

  assign sdio_i = host_oe ? host_bit : (sdio_oe ? sdio_o : 1'b1);

  p3w_reg_target #(.CHIP_ID(T_ID), .CHIP_REV(T_REV)) u_p3w_reg_target (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
    .strap_res(strap_res), .strap_active(strap_active),
    .res_code(res_code), .standby(standby)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_res();
    return m_own ? m_res : strap_res;
  endfunction

  function automatic logic exp_act();
    return m_own ? m_act : strap_active;
  endfunction

  function automatic logic [7:0] exp_read(input logic [5:0] a);
    case (a)
      6'h00: return m_scratch;
      6'h01: return {T_ID, T_REV};
      6'h02: return {5'b0, exp_res()};
      6'h03: return {m_own, 6'b0, exp_act()};
      default: return 8'h00;
    endcase
  endfunction

  task automatic apply_write(input logic [5:0] a, input logic [7:0] d);
    case (a)
      6'h00: m_scratch = d;
      6'h02: m_res = d[2:0];
      6'h03: begin m_own = d[7]; m_act = d[0]; end
      default: ;
    endcase
  endtask

  // per-clock comparison against the reference model while the bus is idle
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      chk("R10/R11 res_code", {5'b0, res_code}, {5'b0, exp_res()});
      chk("R10/R11 standby", {7'b0, standby}, {7'b0, ~exp_act()});
      chk("R6/R7 idle oe", {7'b0, sdio_oe}, 8'h00);
    end
    if (host_oe && sdio_oe) begin
      checks++;
      errors++;
      $display("FAIL R5 contention actual=1 expected=0");
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    host_oe = 1'b1;
    host_bit = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    host_oe = 1'b0;
    wait_clk(2 * HALF);
    mon_on = 1'b1;
  endtask

  task automatic send_write(input logic [5:0] a, input logic [7:0] d,
                            input logic pad, input int nbits);
    logic [15:0] vec;
    vec = {a, 1'b0, pad, d};
    mon_on = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) clock_bit(vec[15 - i]);
    cs_n = 1'b1;
    host_oe = 1'b0;
    wait_clk(2 * HALF);
    if (nbits == 16) apply_write(a, d);
    mon_on = 1'b1;
  endtask

  task automatic do_read(input logic [5:0] a, input int ndata, output logic [7:0] got);
    logic [6:0] cmd;
    cmd = {a, 1'b1};
    got = 8'h00;
    mon_on = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 7; i++) clock_bit(cmd[6 - i]);
    host_oe = 1'b0;
    wait_clk(HALF);
    chk("R5 turnaround oe", {7'b0, sdio_oe}, 8'h00);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
    for (int k = 0; k < ndata; k++) begin
      wait_clk(HALF);
      chk("R6 data oe", {7'b0, sdio_oe}, 8'h01);
      got[7 - k] = sdio_i;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    if (ndata == 8) begin
      wait_clk(HALF);
      chk("R6 release oe", {7'b0, sdio_oe}, 8'h00);
    end
    end_frame();
  endtask

  task automatic read_check(input string req, input logic [5:0] a);
    logic [7:0] got;
    do_read(a, 8, got);
    chk(req, got, exp_read(a));
  endtask

  task automatic set_straps(input logic [2:0] r, input logic act);
    mon_on = 1'b0;
    strap_res = r;
    strap_active = act;
    wait_clk(2);
    mon_on = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] got;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk("R1 oe", {7'b0, sdio_oe}, 8'h00);
    chk("R1 res_code", {5'b0, res_code}, 8'h05);
    chk("R1 standby", {7'b0, standby}, 8'h00);
    mon_on = 1'b1;
    read_check("R1 scratch reset", 6'h00);

    // R3 scratch and R2 pad bit ignored
    send_write(6'h00, 8'h55, 1'b0, 16);
    read_check("R3 scratch 55", 6'h00);
    send_write(6'h00, 8'hA3, 1'b1, 16);
    read_check("R2 R3 pad ignored", 6'h00);

    // R4 identity
    read_check("R4 ident", 6'h01);
    send_write(6'h01, 8'hFF, 1'b0, 16);
    read_check("R4 ident after write", 6'h01);

    // R10 hardware ownership
    read_check("R10 res read strap", 6'h02);
    read_check("R10 pwr read strap", 6'h03);
    set_straps(3'b010, 1'b0);
    read_check("R10 pwr strap low", 6'h03);
    send_write(6'h02, 8'hFE, 1'b0, 16);
    read_check("R10 res still strap", 6'h02);

    // R11 software ownership, R8/R9 field layout
    send_write(6'h03, 8'h81, 1'b0, 16);
    chk("R11 res_code", {5'b0, res_code}, 8'h06);
    chk("R11 standby", {7'b0, standby}, 8'h00);
    read_check("R8 res upper zero", 6'h02);
    read_check("R9 pwr 81", 6'h03);
    send_write(6'h03, 8'hFF, 1'b0, 16);
    read_check("R9 middle bits zero", 6'h03);
    send_write(6'h03, 8'h80, 1'b0, 16);
    chk("R11 standby set", {7'b0, standby}, 8'h01);
    set_straps(3'b111, 1'b1);
    chk("R11 straps ignored res", {5'b0, res_code}, 8'h06);
    chk("R11 straps ignored stby", {7'b0, standby}, 8'h01);
    send_write(6'h03, 8'h01, 1'b0, 16);
    chk("R10 back to straps", {5'b0, res_code}, 8'h07);
    read_check("R10 pwr own cleared", 6'h03);

    // R12 unmapped and R2 MSB-first address order
    send_write(6'h20, 8'h77, 1'b0, 16);
    read_check("R12 read 20", 6'h20);
    read_check("R12 read 3F", 6'h3F);
    read_check("R12 R2 scratch intact", 6'h00);
    read_check("R12 read 04", 6'h04);

    // R7 aborted write and aborted read
    send_write(6'h00, 8'h11, 1'b0, 12);
    read_check("R7 aborted write", 6'h00);
    send_write(6'h03, 8'h81, 1'b0, 15);
    read_check("R7 aborted pwr write", 6'h03);
    do_read(6'h01, 3, got);
    chk("R7 partial read bits", {5'b0, got[7:5]}, {5'b0, T_ID[3:1]});
    wait_clk(4);
    chk("R7 oe released", {7'b0, sdio_oe}, 8'h00);
    read_check("R7 read after abort", 6'h01);

    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule